// File: doc/BRIEF.md
# Four-Bank Interleaved Block Fill Memory

This block is the backing store behind a cache. It holds its contents in four one-word-wide banks. Word address bits [1:0] pick the bank, so the four words of an aligned 4-word block sit in four different banks. A block read sends its row address to all four banks in the same cycle. The four array accesses therefore overlap, and the words then come back one per cycle over a one-word response bus. A fill takes 1 address cycle, 15 access cycles and 4 transfer cycles, which is 20 cycles in total.

Single-word writes occupy only the bank they target. Writes to different banks are accepted on back-to-back cycles and run side by side. A request to a bank that is still inside its access window is held off by a low `reqReady`. `reqReady` is a function of the request presented (its kind and bank) and of the banks' busy state.

Top module: `ibank_fill_mem`

## Requirements
- R1: After reset, `rspValid` and `rspLast` are low, `reqReady` is high for both a read and a write, and every stored word reads as zero.
- R2: For a block read accepted at clock edge E, the first word is on the response bus during the 17th cycle after E and the last during the 20th cycle (address 1 + access 15 + four 1-cycle beats).
- R3: A block read (`reqWrite`=0) returns the words at word addresses {A[7:2],2'b00} through {A[7:2],2'b11} in ascending bank order; bits A[1:0] of a read address are ignored.
- R4: The four beats of a fill are on consecutive cycles, `rspLast` is high on the fourth beat only, and `rspValid` is low in the cycle after it.
- R5: A write (`reqWrite`=1) stores `reqWdata` in bank A[1:0] at row A[7:2], and a later block read covering that address returns the new value.
- R6: After a write to bank b is accepted at edge E, `reqReady` stays low for another write to bank b in cycles 1 to 16 after E, and is high in cycle 17.
- R7: Writes to four distinct banks are each accepted in the cycle they are presented, on four consecutive cycles.
- R8: `reqReady` for a read stays low from acceptance of a block read until its last beat has been sent, and is high in the cycle after the last beat.
- R9: The words of a fill are captured when the banks finish their access, so a write to one of those banks that is accepted during the beats does not change the words returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqWrite | input | 1 | 1 = single-word write, 0 = block read |
| reqAddr | input | ADDR_W (8) | Word address; bits [1:0] select the bank |
| reqWdata | input | DATA_W (32) | Write data |
| rspValid | output | 1 | Response beat valid |
| rspLast | output | 1 | Fourth beat of a fill |
| rspData | output | DATA_W (32) | Response word |

## Verification
The embedded properties check on every cycle that beats run back to back and end with one flagged last beat, that the fill data is captured exactly at the programmed access latency, that a pending fill never overlaps one that is still transferring, and that no two bank writes commit in the same cycle. Some behaviour only the directed scenarios can show: the word values and their order, the cycle-exact ready windows for busy banks and for reads, that low read address bits are ignored, and that a write issued during the beats leaves the returned block unchanged.

// File: rtl/ibank_pkg.sv
package ibank_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_BITS = $clog2(NUM_BANKS);

  typedef struct packed {
    logic [NUM_BANKS-1:0] latchReq;
    logic [NUM_BANKS-1:0] commitWr;
    logic                 captureFill;
    logic                 beatValid;
    logic                 beatLast;
    logic [BANK_BITS-1:0] beatSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/ibank_ctrl.sv
module ibank_ctrl
  import ibank_pkg::*;
#(
  parameter int ADDR_CYC   = 1,
  parameter int ACCESS_CYC = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [BANK_BITS-1:0] reqBank,
  output logic                 reqReady,
  output ctrlStrobe_t          strobe
);
  localparam int LOAD  = ADDR_CYC + ACCESS_CYC;
  localparam int TW    = $clog2(LOAD + 1);
  localparam int AGE_W = $clog2(LOAD + 2) + 1;

  logic [TW-1:0]        bankTimer [NUM_BANKS];
  logic [NUM_BANKS-1:0] bankIsWrite;
  logic [NUM_BANKS-1:0] bankIdle;
  logic [NUM_BANKS-1:0] bankStart;
  logic                 readPending;
  logic                 beatActive;
  logic [BANK_BITS-1:0] beatSel;
  logic                 allIdle, readReady, accept, acceptWr, acceptRd;
  logic                 captureFill;

  assign allIdle   = &bankIdle;
  assign readReady = allIdle && !readPending && !beatActive;
  assign reqReady  = reqWrite ? bankIdle[reqBank] : readReady;
  assign accept    = reqValid && reqReady;
  assign acceptWr  = accept && reqWrite;
  assign acceptRd  = accept && !reqWrite;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bankIdle[b]  = (bankTimer[b] == '0);
    assign bankStart[b] = acceptRd || (acceptWr && (reqBank == BANK_BITS'(b)));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankTimer[b]   <= '0;
        bankIsWrite[b] <= 1'b0;
      end else if (bankStart[b]) begin
        bankTimer[b]   <= TW'(LOAD);
        bankIsWrite[b] <= reqWrite;
      end else if (!bankIdle[b]) begin
        bankTimer[b]   <= bankTimer[b] - TW'(1);
      end
    end

    assign strobe.commitWr[b] = bankIsWrite[b] && (bankTimer[b] == TW'(1));
  end

  assign strobe.latchReq = bankStart;
  assign captureFill     = readPending && (bankTimer[0] == TW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readPending <= 1'b0;
      beatActive  <= 1'b0;
      beatSel     <= '0;
    end else begin
      if (acceptRd)         readPending <= 1'b1;
      else if (captureFill) readPending <= 1'b0;
      if (captureFill) begin
        beatActive <= 1'b1;
        beatSel    <= '0;
      end else if (beatActive) begin
        if (beatSel == BANK_BITS'(NUM_BANKS - 1)) beatActive <= 1'b0;
        beatSel <= beatSel + BANK_BITS'(1);
      end
    end
  end

  assign strobe.captureFill = captureFill;
  assign strobe.beatValid   = beatActive;
  assign strobe.beatSel     = beatSel;
  assign strobe.beatLast    = beatActive && (beatSel == BANK_BITS'(NUM_BANKS - 1));

  // cycle count since the last accepted block read, used by the latency check
  logic [AGE_W-1:0] fillAge;
  always_ff @(posedge clk) begin
    if (!rstN)                                   fillAge <= '0;
    else if (acceptRd)                           fillAge <= AGE_W'(1);
    else if (fillAge != '0 && fillAge != '1)     fillAge <= fillAge + AGE_W'(1);
  end

  // R2
  fill_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    captureFill |-> (fillAge == AGE_W'(LOAD)));
  // R4
  beat_contig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.beatValid && !strobe.beatLast) |=> strobe.beatValid);
  // R4
  single_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.beatLast |=> !strobe.beatValid);
  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    readPending |-> !beatActive);
endmodule

// File: rtl/ibank_dp.sv
module ibank_dp
  import ibank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic              rspLast,
  output logic [DATA_W-1:0] rspData
);
  localparam int ROW_W = ADDR_W - BANK_BITS;
  localparam int ROWS  = 1 << ROW_W;

  logic [DATA_W-1:0] bankOut [NUM_BANKS];
  logic [DATA_W-1:0] fillBuf [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] store [ROWS];
    logic [ROW_W-1:0]  rowReg;
    logic [DATA_W-1:0] dataReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int r = 0; r < ROWS; r++) store[r] <= '0;
        rowReg  <= '0;
        dataReg <= '0;
      end else begin
        if (strobe.latchReq[b]) begin
          rowReg  <= reqAddr[ADDR_W-1:BANK_BITS];
          dataReg <= reqWdata;
        end
        if (strobe.commitWr[b]) store[rowReg] <= dataReg;
      end
    end

    assign bankOut[b] = store[rowReg];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++) fillBuf[b] <= '0;
    end else if (strobe.captureFill) begin
      for (int b = 0; b < NUM_BANKS; b++) fillBuf[b] <= bankOut[b];
    end
  end

  assign rspValid = strobe.beatValid;
  assign rspLast  = strobe.beatLast;
  assign rspData  = strobe.beatValid ? fillBuf[strobe.beatSel] : '0;

  // R7
  one_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.commitWr));
  // R9
  capture_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureFill |-> (strobe.commitWr == '0));
endmodule

// File: rtl/ibank_fill_mem.sv
module ibank_fill_mem
  import ibank_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int ADDR_CYC   = 1,
  parameter int ACCESS_CYC = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic              rspLast,
  output logic [DATA_W-1:0] rspData
);
  ctrlStrobe_t strobe;

  ibank_ctrl #(.ADDR_CYC(ADDR_CYC), .ACCESS_CYC(ACCESS_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBank(reqAddr[BANK_BITS-1:0]), .reqReady(reqReady), .strobe(strobe)
  );

  ibank_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspLast(rspLast), .rspData(rspData)
  );
endmodule

// File: tb/test_ibank_fill_mem.sv
module test_ibank_fill_mem;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid, rspLast;
  logic [31:0] rspData;

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] model [256];

  ibank_fill_mem i_ibank_fill_mem (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspLast(rspLast), .rspData(rspData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_ready();
    #1;
    while (!reqReady) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check("R1 rspValid", {31'b0, rspValid}, 32'd0);
    check("R1 rspLast", {31'b0, rspLast}, 32'd0);
    reqWrite = 1'b0; #1;
    check("R1 read ready", {31'b0, reqReady}, 32'd1);
    reqWrite = 1'b1; reqAddr = 8'h22; #1;
    check("R1 write ready", {31'b0, reqReady}, 32'd1);
    reqWrite = 1'b0;
  endtask

  // block read; optionally a write to sideAddr presented in cycle 17
  task automatic t_fill(logic [7:0] addr, bit side, logic [7:0] sideAddr, logic [31:0] sideData);
    logic [31:0] snap [4];
    logic [7:0] base;
    base = {addr[7:2], 2'b00};
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = addr;
    wait_ready();
    for (int i = 0; i < 4; i++) snap[i] = model[base + 8'(i)];
    @(posedge clk);
    for (int k = 1; k <= 21; k++) begin
      @(negedge clk);
      if (k == 1) reqValid = 1'b0;
      if (side && k == 17) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = sideAddr; reqWdata = sideData;
        #1;
        check("R9 side write ready", {31'b0, reqReady}, 32'd1);
        model[sideAddr] = sideData;
      end
      if (k == 18) begin
        reqValid = 1'b0; reqWrite = 1'b0;
      end
      #1;
      if (k >= 17 && k <= 20) begin
        check("R2 beat valid", {31'b0, rspValid}, 32'd1);
        check(side ? "R9 beat data" : "R3 beat data", rspData, snap[k-17]);
        check("R4 last flag", {31'b0, rspLast}, {31'b0, (k == 20)});
      end else begin
        check("R2/R4 idle valid", {31'b0, rspValid}, 32'd0);
      end
      if (!side && (k == 10 || k >= 17)) begin
        reqWrite = 1'b0; #1;
        check("R8 read ready", {31'b0, reqReady}, {31'b0, (k == 21)});
      end
    end
  endtask

  task automatic t_parallel();
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      reqValid = 1'b1; reqWrite = 1'b1;
      reqAddr = 8'h10 + 8'(i); reqWdata = 32'hA000_0000 + 32'(i * 17 + 3);
      #1;
      check("R7 distinct bank ready", {31'b0, reqReady}, 32'd1);
      model[reqAddr] = reqWdata;
      @(posedge clk);
      @(negedge clk);
    end
    reqValid = 1'b0; reqWrite = 1'b0;
    repeat (17) @(negedge clk);
  endtask

  task automatic t_busy();
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 8'h21; reqWdata = 32'h1234_5678;
    wait_ready();
    model[8'h21] = 32'h1234_5678;
    @(posedge clk);
    for (int k = 1; k <= 17; k++) begin
      @(negedge clk);
      reqValid = 1'b0; reqWrite = 1'b1;
      if (k == 1) begin
        reqAddr = 8'h22; #1;
        check("R7 other bank ready", {31'b0, reqReady}, 32'd1);
      end
      reqAddr = 8'h21; #1;
      check("R6 busy bank ready", {31'b0, reqReady}, {31'b0, (k == 17)});
    end
    reqWrite = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_fill(8'h00, 1'b0, 8'h00, 32'h0);                 // R1 R2 R3 R4 R8
    t_parallel();                                      // R7
    t_fill(8'h12, 1'b0, 8'h00, 32'h0);                 // R3 R5
    t_busy();                                          // R6
    t_fill(8'h23, 1'b0, 8'h00, 32'h0);                 // R5
    t_fill(8'h10, 1'b1, 8'h11, 32'hDEAD_BEEF);         // R9
    t_fill(8'h11, 1'b0, 8'h00, 32'h0);                 // R5 after side write
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule